// File: doc/BRIEF.md
# Eight-Channel SDRAM Word Address Generator

This block produces the word addresses for transfers into or out of a 64-bit-wide SDRAM on behalf of eight independent channels. Software programs each channel through a small register bus: a start word address, a transfer length in words, and a control byte. When a channel is started, it steps its word address once for each beat the SDRAM controller accepts. It counts beats from 1 up to the programmed length, and then it reports completion on a per-channel done line.

Each beat leaves the block on a registered valid/ready interface that carries the word address, the transfer direction, the mode bit, the channel number and a last-beat marker. When several channels are active at once, a round-robin arbiter issues one beat per cycle, taking the channels in turn. A channel can either reload its programmed start address or continue from the word after the one where it last stopped.

Retrieve is the read-from-SDRAM capture/retrieve mode. The block enforces its rules: at most one channel may retrieve at a time, and only the first channel of each bank of four may do so. Any start that breaks these rules, or that asks for a zero length, is refused and raises a per-channel error line.

Top module: `sdram_agen`

## Requirements
- R1: Register offsets are formed as bank*0x100 + field + 4*k, where the channel is bank*4+k. The fields are: start word address at field 0x20, length at field 0x60, control at field 0xA0. Channels 0-3 therefore have control at 0x0A0/0x0A4/0x0A8/0x0AC and channels 4-7 at 0x1A0/0x1A4/0x1A8/0x1AC. A read request returns its data on `reg_rdata` one cycle later. Start address and length registers read back as written.
- R2: The control byte is laid out as follows. Bit 7 is start. Bits 6:3 are unused. Bit 2 is direction (1 = write to SDRAM, 0 = read from SDRAM). Bit 1 is mode (0 = capture/retrieve, 1 = direct). Bit 0 is load (0 = preload the start address, 1 = continue from the next address). On read-back, bits 6:3 and all upper bits are zero, bits 2:0 return the last written values, and bit 7 reads 1 while the channel is busy.
- R3: A start with load = 0 issues its first beat at the programmed start address, and each following beat of that channel carries the next word address. Every beat carries `sd_wr` equal to control bit 2 and `sd_direct` equal to control bit 1.
- R4: A start with length N (N >= 1) issues exactly N beats. Only the Nth beat has `sd_last` = 1. Once that beat is accepted, `ch_done` for the channel goes high and control bit 7 reads back as 0.
- R5: A start with load = 1 continues at the word after the last beat the channel issued before.
- R6: A start with length 0 issues no beats and sets `ch_err` for that channel.
- R7: A retrieve start (bit 2 = 0 and bit 1 = 0) on any channel other than 0 or 4 issues no beats and sets `ch_err` for that channel.
- R8: A retrieve start while another channel is busy in retrieve issues no beats and sets `ch_err` for the refused channel. At most one channel is ever busy in retrieve.
- R9: Any write to a channel's control register clears that channel's `ch_done` and `ch_err`. A control write with bit 7 = 0 does not start the channel.
- R10: When several channels are active, beats are granted round robin. With all eight channels active, consecutive beats come from channels in ascending order and wrap from 7 to 0.
- R11: While `sd_valid` is high and `sd_ready` is low, `sd_valid`, `sd_addr` and `sd_ch` hold steady. A channel advances only by beats that are actually accepted, so no beat is lost or repeated.
- R12: The word address wraps modulo 2^26, so the word after 0x3FFFFFF is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 26 | Register write data |
| reg_rdata | output | 26 | Register read data, valid one cycle after `reg_rd` |
| sd_valid | output | 1 | A beat is presented to the SDRAM controller |
| sd_ready | input | 1 | The SDRAM controller accepts the beat |
| sd_addr | output | 26 | Word address of the beat |
| sd_wr | output | 1 | 1 = write to SDRAM, 0 = read from SDRAM |
| sd_direct | output | 1 | 1 = direct mode, 0 = capture/retrieve |
| sd_ch | output | 3 | Channel that owns the beat |
| sd_last | output | 1 | Final beat of the channel's transfer |
| ch_done | output | 8 | Per-channel transfer complete |
| ch_err | output | 8 | Per-channel refused start |

## Verification
The assertions assume a single-master register bus that presents at most one write per cycle. They also assume that software does not restart a channel while that channel's final beat is still waiting for acceptance, because a restart at that point would break the busy-to-done handoff the checks rely on. The bench issues every register access through one task and waits for `ch_done` before it reuses a channel. It varies `sd_ready` (held low, held high, toggling every cycle) so that stalls fall at many beat positions without breaking those assumptions.

// File: rtl/agen_pkg.sv
package agen_pkg;

  // control byte bit positions
  localparam int BIT_START = 7;
  localparam int BIT_IO    = 2;
  localparam int BIT_DIR   = 1;
  localparam int BIT_LOAD  = 0;

  // register field selectors, reg_addr[7:4]
  localparam logic [3:0] FLD_ADDR = 4'h2;
  localparam logic [3:0] FLD_LEN  = 4'h6;
  localparam logic [3:0] FLD_CTRL = 4'hA;

  // channels per 0x100 bank
  localparam int BANK = 4;

  typedef struct packed {
    logic start;
    logic io;
    logic direct;
    logic cont;
  } ctrl_t;

endpackage

// File: rtl/agen_regs.sv
module agen_regs
  import agen_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 26,
  parameter int RA_W   = 12,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic [RA_W-1:0]                reg_addr,
  input  logic [ADDR_W-1:0]              reg_wdata,
  input  logic [NUM_CH-1:0]              ch_busy,
  output logic [ADDR_W-1:0]              reg_rdata,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  base_addr,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  xfer_len,
  output logic [NUM_CH-1:0]              ctrl_wr,
  output ctrl_t                          ctrl_bits
);

  localparam int GRP_W = RA_W - 8;

  logic [GRP_W+1:0]         ch_full;
  logic                     hit;
  logic [CH_W-1:0]          ch_idx;
  logic [3:0]               fld;
  logic [NUM_CH-1:0][2:0]   mode_q;

  // decode: channel = bank*4 + k
  always_comb begin
    ch_full = {reg_addr[RA_W-1:8], reg_addr[3:2]};
    hit     = (reg_addr[1:0] == 2'b00) && (int'(ch_full) < NUM_CH);
    ch_idx  = ch_full[CH_W-1:0];
    fld     = reg_addr[7:4];
  end

  always_comb begin
    ctrl_bits.start  = reg_wdata[BIT_START];
    ctrl_bits.io     = reg_wdata[BIT_IO];
    ctrl_bits.direct = reg_wdata[BIT_DIR];
    ctrl_bits.cont   = reg_wdata[BIT_LOAD];
    ctrl_wr = '0;
    if (reg_wr && hit && fld == FLD_CTRL) ctrl_wr[ch_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      xfer_len  <= '0;
      mode_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && hit) begin
        case (fld)
          FLD_ADDR: base_addr[ch_idx] <= reg_wdata;
          FLD_LEN:  xfer_len[ch_idx]  <= reg_wdata;
          FLD_CTRL: mode_q[ch_idx]    <= reg_wdata[2:0];
          default: ;
        endcase
      end
      if (reg_rd) begin
        reg_rdata <= '0;
        if (hit) begin
          case (fld)
            FLD_ADDR: reg_rdata <= base_addr[ch_idx];
            FLD_LEN:  reg_rdata <= xfer_len[ch_idx];
            FLD_CTRL: reg_rdata[7:0] <= {ch_busy[ch_idx], 4'b0000, mode_q[ch_idx]};
            default: ;
          endcase
        end
      end
    end
  end

  AST_CTRL_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && hit && fld == FLD_CTRL) |=> (reg_rdata[6:3] == 4'b0000)); // R2

  AST_ONE_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl_wr)); // R9

endmodule

// File: rtl/agen_chan.sv
module agen_chan
  import agen_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  ctrl_t             ctrl_bits,
  input  logic              reject,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] xfer_len,
  input  logic              take,
  input  logic              acc_last,
  output logic              run,
  output logic              busy,
  output logic              retr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_dir,
  output logic              direct,
  output logic              last,
  output logic              done,
  output logic              err
);

  logic [ADDR_W-1:0] cnt;
  logic [ADDR_W-1:0] len_l;
  logic              pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      pend     <= 1'b0;
      cnt      <= '0;
      len_l    <= '0;
      cur_addr <= '0;
      wr_dir   <= 1'b0;
      direct   <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        done <= 1'b0;
        err  <= 1'b0;
        if (ctrl_bits.start) begin
          if (reject) begin
            err <= 1'b1;
            run <= 1'b0;
          end else begin
            run    <= 1'b1;
            cnt    <= ADDR_W'(1);
            len_l  <= xfer_len;
            wr_dir <= ctrl_bits.io;
            direct <= ctrl_bits.direct;
            if (!ctrl_bits.cont) cur_addr <= base_addr;
          end
        end else begin
          run <= 1'b0;
        end
      end else if (take) begin
        cur_addr <= cur_addr + ADDR_W'(1);
        if (cnt == len_l) begin
          run  <= 1'b0;
          pend <= 1'b1;
        end else begin
          cnt <= cnt + ADDR_W'(1);
        end
      end
      if (acc_last) begin
        pend <= 1'b0;
        if (!ctrl_wr) done <= 1'b1;
      end
    end
  end

  assign last = (cnt == len_l);
  assign busy = run | pend;
  assign retr = busy & ~wr_dir & ~direct;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0 && cnt <= len_l)); // R4

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_bits.start && xfer_len == '0) |=> (!run && err)); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (take && !ctrl_wr) |=> (cur_addr == $past(cur_addr) + ADDR_W'(1))); // R3

  AST_TAKE_RUN: assert property (@(posedge clk) disable iff (rst)
    take |-> (run && !ctrl_wr)); // R11

endmodule

// File: rtl/agen_rr_arb.sv
module agen_rr_arb #(
  parameter int N   = 8,
  parameter int IW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);

  logic [IW-1:0] ptr;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int o = 0; o < N; o++) begin
      int j;
      j = (int'(ptr) + o) % N;
      if (!gnt_any && req[j]) begin
        gnt_any = 1'b1;
        gnt[j]  = 1'b1;
        gnt_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (en && gnt_any) begin
      ptr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + IW'(1);
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt)); // R10

  AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (rst)
    ((gnt & ~req) == '0) && (gnt_any == (req != '0))); // R10

endmodule

// File: rtl/sdram_agen.sv
module sdram_agen
  import agen_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int ADDR_W      = 26,
  parameter int RA_W        = 12,
  parameter int RETR_STRIDE = 4,
  parameter int CH_W        = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [ADDR_W-1:0]  reg_wdata,
  output logic [ADDR_W-1:0]  reg_rdata,
  output logic               sd_valid,
  input  logic               sd_ready,
  output logic [ADDR_W-1:0]  sd_addr,
  output logic               sd_wr,
  output logic               sd_direct,
  output logic [CH_W-1:0]    sd_ch,
  output logic               sd_last,
  output logic [NUM_CH-1:0]  ch_done,
  output logic [NUM_CH-1:0]  ch_err
);

  logic [NUM_CH-1:0][ADDR_W-1:0] base_addr;
  logic [NUM_CH-1:0][ADDR_W-1:0] xfer_len;
  logic [NUM_CH-1:0]             ctrl_wr;
  ctrl_t                         ctrl_bits;

  logic [NUM_CH-1:0] ch_run, ch_busy, ch_retr, ch_wr, ch_dir, ch_last;
  logic [NUM_CH-1:0] reject, take, acc_last, retr_pos;
  logic [ADDR_W-1:0] ch_addr [NUM_CH];

  logic [NUM_CH-1:0] gnt;
  logic [CH_W-1:0]   gnt_idx;
  logic              gnt_any;
  logic              load_en;
  logic              retr_req;

  agen_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .RA_W   (RA_W),
    .CH_W   (CH_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ch_busy   (ch_busy),
    .reg_rdata (reg_rdata),
    .base_addr (base_addr),
    .xfer_len  (xfer_len),
    .ctrl_wr   (ctrl_wr),
    .ctrl_bits (ctrl_bits)
  );

  assign retr_req = ~ctrl_bits.io & ~ctrl_bits.direct;
  assign load_en  = ~sd_valid | sd_ready;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam bit              POS_OK = (i % RETR_STRIDE) == 0;
    localparam logic [NUM_CH-1:0] SELF = NUM_CH'(1) << i;

    assign retr_pos[i] = POS_OK;
    assign reject[i]   = (xfer_len[i] == '0) ||
                         (retr_req && (!POS_OK || ((ch_retr & ~SELF) != '0)));
    assign take[i]     = gnt[i] & load_en;
    assign acc_last[i] = sd_valid & sd_ready & sd_last & (sd_ch == CH_W'(i));

    agen_chan #(
      .ADDR_W (ADDR_W)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .ctrl_wr   (ctrl_wr[i]),
      .ctrl_bits (ctrl_bits),
      .reject    (reject[i]),
      .base_addr (base_addr[i]),
      .xfer_len  (xfer_len[i]),
      .take      (take[i]),
      .acc_last  (acc_last[i]),
      .run       (ch_run[i]),
      .busy      (ch_busy[i]),
      .retr      (ch_retr[i]),
      .cur_addr  (ch_addr[i]),
      .wr_dir    (ch_wr[i]),
      .direct    (ch_dir[i]),
      .last      (ch_last[i]),
      .done      (ch_done[i]),
      .err       (ch_err[i])
    );
  end

  agen_rr_arb #(
    .N  (NUM_CH),
    .IW (CH_W)
  ) u_arb (
    .clk     (clk),
    .rst     (rst),
    .en      (load_en),
    .req     (ch_run & ~ctrl_wr),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_valid  <= 1'b0;
      sd_addr   <= '0;
      sd_wr     <= 1'b0;
      sd_direct <= 1'b0;
      sd_ch     <= '0;
      sd_last   <= 1'b0;
    end else if (load_en) begin
      sd_valid <= gnt_any;
      if (gnt_any) begin
        sd_addr   <= ch_addr[gnt_idx];
        sd_wr     <= ch_wr[gnt_idx];
        sd_direct <= ch_dir[gnt_idx];
        sd_ch     <= gnt_idx;
        sd_last   <= ch_last[gnt_idx];
      end
    end
  end

  AST_ONE_RETRIEVE: assert property (@(posedge clk) disable iff (rst)
    $countones(ch_retr) <= 1); // R8

  AST_RETRIEVE_POS: assert property (@(posedge clk) disable iff (rst)
    (ch_retr & ~retr_pos) == '0); // R7

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sd_valid && !sd_ready) |=> (sd_valid && $stable(sd_addr) && $stable(sd_ch))); // R11

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (acc_last != '0 && ctrl_wr == '0) |=> ((ch_done & $past(acc_last)) == $past(acc_last))); // R4

endmodule

// File: tb/sdram_agen_tb.sv
module sdram_agen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int AW  = 26;
  localparam logic [AW-1:0] AMASK = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic sd_valid, sd_ready, sd_wr, sd_direct, sd_last;
  logic [AW-1:0] sd_addr;
  logic [2:0] sd_ch;
  logic [NCH-1:0] ch_done, ch_err;

  int n_chk = 0, n_fail = 0, mon_err = 0, cyc = 0, rdy_mode = 0;
  int acc_cnt [NCH];
  int exp_left [NCH];
  logic [AW-1:0] exp_addr [NCH];
  logic [AW-1:0] last_addr [NCH];
  logic exp_wr [NCH];
  logic exp_dir [NCH];
  int log_ch [64];
  int log_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_agen u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_valid(sd_valid), .sd_ready(sd_ready),
    .sd_addr(sd_addr), .sd_wr(sd_wr), .sd_direct(sd_direct), .sd_ch(sd_ch),
    .sd_last(sd_last), .ch_done(ch_done), .ch_err(ch_err)
  );

  initial sd_ready = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (rdy_mode)
      0: sd_ready = 1'b0;
      1: sd_ready = 1'b1;
      default: sd_ready = cyc[0];
    endcase
  end

  // beat monitor: inputs only change just after posedge, so values at negedge hold at the next edge
  always @(negedge clk) begin
    if (!rst && sd_valid && sd_ready) begin
      int c;
      c = int'(sd_ch);
      acc_cnt[c]++;
      exp_left[c]--;
      if (sd_addr !== exp_addr[c] || sd_wr !== exp_wr[c] || sd_direct !== exp_dir[c] ||
          sd_last !== (exp_left[c] == 0)) begin
        mon_err++;
        $display("beat mismatch ch%0d addr=%0h exp=%0h", c, sd_addr, exp_addr[c]);
      end
      last_addr[c] = sd_addr;
      exp_addr[c]  = (sd_addr + 1'b1) & AMASK;
      if (log_n < 64) begin
        log_ch[log_n] = c;
        log_n++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] off(input int ch, input int fld);
    return 12'((ch / 4) * 256 + fld + (ch % 4) * 4);
  endfunction

  task automatic wr_reg(input logic [11:0] a, input logic [AW-1:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [AW-1:0] d);
    @(posedge clk); #1;
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic setup(input int ch, input logic [AW-1:0] base, input int len, input logic [7:0] ctl);
    wr_reg(off(ch, 'h20), base);
    wr_reg(off(ch, 'h60), AW'(len));
    if (!ctl[0]) exp_addr[ch] = base;
    exp_left[ch] = len;
    exp_wr[ch]   = ctl[2];
    exp_dir[ch]  = ctl[1];
    acc_cnt[ch]  = 0;
    wr_reg(off(ch, 'hA0), AW'(ctl));
  endtask

  task automatic wait_done(input int ch);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (ch_done[ch]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [AW-1:0] rd, a0;
    for (int i = 0; i < NCH; i++) begin
      acc_cnt[i] = 0; exp_left[i] = 0; exp_addr[i] = '0; last_addr[i] = '0;
      exp_wr[i] = 1'b0; exp_dir[i] = 1'b0;
    end
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // reset state
    check("R4 reset sd_valid", 32'(sd_valid), 0);
    check("R4 reset ch_done", 32'(ch_done), 0);
    check("R6 reset ch_err", 32'(ch_err), 0);
    rd_reg(off(3, 'hA0), rd);
    check("R2 reset ctrl readback", 32'(rd), 0);

    // R1: map sweep over all channels
    for (int c = 0; c < NCH; c++) begin
      wr_reg(off(c, 'h20), AW'(32'h1000 + c * 32'h111));
      wr_reg(off(c, 'h60), AW'(c + 1));
    end
    for (int c = 0; c < NCH; c++) begin
      rd_reg(off(c, 'h20), rd);
      check("R1 start address readback", 32'(rd), 32'h1000 + c * 32'h111);
      rd_reg(off(c, 'h60), rd);
      check("R1 length readback", 32'(rd), 32'(c + 1));
    end
    // R2: unused bits masked, no start
    wr_reg(off(5, 'hA0), AW'(8'h7F));
    rd_reg(off(5, 'hA0), rd);
    check("R2 ctrl readback masks bits 6:3", 32'(rd), 32'h07);
    check("R9 no start when bit7 clear", 32'(sd_valid), 0);

    // R3 R4: ch1 capture write, preload
    rdy_mode = 1;
    setup(1, AW'(32'h100), 5, 8'h84);
    rd_reg(off(1, 'hA0), rd);
    check("R2 busy reads bit7", 32'(rd[7]), 1);
    wait_done(1);
    @(negedge clk);
    check("R4 beat count N=5", 32'(acc_cnt[1]), 5);
    check("R3 addresses and direction", 32'(mon_err), 0);
    check("R4 done set", 32'(ch_done[1]), 1);
    rd_reg(off(1, 'hA0), rd);
    check("R4 start bit clears", 32'(rd), 32'h04);

    // R5: continue from next address
    wr_reg(off(1, 'h60), AW'(3));
    exp_left[1] = 3; acc_cnt[1] = 0;
    wr_reg(off(1, 'hA0), AW'(8'h85));
    wait_done(1);
    @(negedge clk);
    check("R5 continue beat count", 32'(acc_cnt[1]), 3);
    check("R5 continue last address", 32'(last_addr[1]), 32'h107);
    check("R5 monitor", 32'(mon_err), 0);
    wr_reg(off(1, 'hA0), AW'(8'h05));
    check("R9 done cleared by ctrl write", 32'(ch_done[1]), 0);

    // R6: zero length
    setup(2, AW'(32'h40), 0, 8'h86);
    repeat (6) @(negedge clk);
    check("R6 zero length err", 32'(ch_err[2]), 1);
    check("R6 zero length no beats", 32'(acc_cnt[2]), 0);
    wr_reg(off(2, 'hA0), AW'(8'h00));
    check("R9 err cleared by ctrl write", 32'(ch_err[2]), 0);

    // R7: retrieve on a disallowed channel
    setup(3, AW'(32'h80), 4, 8'h80);
    repeat (6) @(negedge clk);
    check("R7 retrieve on ch3 err", 32'(ch_err[3]), 1);
    check("R7 retrieve on ch3 no beats", 32'(acc_cnt[3]), 0);

    // R11 R8: stalled retrieve on ch0, refused retrieve on ch4
    rdy_mode = 0;
    setup(0, AW'(32'h2000), 20, 8'h80);
    @(negedge clk); @(negedge clk);
    a0 = sd_addr;
    repeat (3) @(negedge clk);
    check("R11 valid held under stall", 32'(sd_valid), 1);
    check("R11 address held under stall", 32'(sd_addr), 32'(a0));
    check("R3 first beat at start address", 32'(a0), 32'h2000);
    setup(4, AW'(32'h3000), 5, 8'h80);
    repeat (3) @(negedge clk);
    check("R8 second retrieve refused", 32'(ch_err[4]), 1);
    check("R8 ch0 unaffected", 32'(ch_err[0]), 0);
    rdy_mode = 2;
    wait_done(0);
    @(negedge clk);
    check("R11 stalled beats all arrive", 32'(acc_cnt[0]), 20);
    check("R8 refused channel silent", 32'(acc_cnt[4]), 0);
    check("R11 monitor", 32'(mon_err), 0);

    // R10: all eight channels round robin
    rdy_mode = 0;
    for (int c = 0; c < NCH; c++) setup(c, AW'(32'h10000 + c * 32'h100), 4, 8'h86);
    log_n = 0;
    rdy_mode = 1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (ch_done == 8'hFF) break;
    end
    check("R10 total beats", 32'(log_n), 32);
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 32; k++) if (log_ch[k] != k % NCH) bad++;
      check("R10 rotation order", 32'(bad), 0);
    end
    check("R10 monitor", 32'(mon_err), 0);

    // R12: wrap
    rdy_mode = 2;
    setup(6, AW'(32'h3FFFFFE), 4, 8'h86);
    wait_done(6);
    @(negedge clk);
    check("R12 wrap beat count", 32'(acc_cnt[6]), 4);
    check("R12 wrapped last address", 32'(last_addr[6]), 1);
    check("R12 monitor", 32'(mon_err), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule